// File: doc/BRIEF.md
# Half-Bias Write Pulse Sequencer

This block times one write operation on a resistive crossbar driven under a half-voltage bias scheme. A start command first raises the precharge enable, which holds every unselected word and bit line at half the write amplitude while the strobe switch is still open. After a programmable settle interval the strobe closes, so the full amplitude reaches the selected line for the pulse width. The strobe then either repeats for the remaining pulses of a burst, with the precharge held between them, or the block drops everything and lets the array return to ground.

All intervals are programmed in clock ticks and captured at start, together with the amplitude code and the polarity. The amplitude and polarity go straight to the analog drive path; the precharge and strobe outputs control the bias switches. An abort input tears the operation down on the next cycle.

Top module: `hb_write_seq`

## Requirements
- R1: In the settle phase that follows an accepted start, precharge_en is high and strobe is low for max(settle_ticks,1) cycles, beginning in the cycle after the start edge.
- R2: Each pulse holds strobe high for max(width_ticks,1) cycles; precharge_en stays high throughout, and strobe never goes high unless precharge_en was high in the previous cycle.
- R3: A burst delivers max(pulse_count,1) pulses after a single settle phase; between two pulses strobe is low and precharge_en stays high for max(gap_ticks,1) cycles.
- R4: A pulse_count of 0 delivers exactly one pulse, and any tick setting of 0 lasts one cycle.
- R5: After the last pulse, precharge_en and strobe are low and busy is high for max(gnd_ticks,1) cycles; done is then high for exactly one cycle, during which busy is low.
- R6: When abort is high at a clock edge, precharge_en, strobe and busy are low in the following cycle and no done follows for that operation.
- R7: amp_code and polarity equal the values of amp_in and pol_in at the accepted start for the whole operation, and are 0 while busy is low; input changes during the operation have no effect.
- R8: start is ignored while busy is high; the interval settings are also captured at start, and changes during the operation have no effect.
- R9: After reset, precharge_en, strobe, busy, done, amp_code and polarity are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a write operation (accepted only when idle) |
| abort | input | 1 | Drop strobe and precharge and go idle |
| settle_ticks | input | TW | Precharge settle interval in ticks |
| width_ticks | input | TW | Pulse width in ticks |
| gap_ticks | input | TW | Gap between burst pulses in ticks |
| gnd_ticks | input | TW | Return-to-ground interval in ticks |
| pulse_count | input | NW | Pulses per burst (0 means 1) |
| amp_in | input | AW | Amplitude code for the operation |
| pol_in | input | 1 | Polarity for the operation |
| precharge_en | output | 1 | Drive inactive lines to half amplitude |
| strobe | output | 1 | Close the strobe switch to the active line |
| amp_code | output | AW | Captured amplitude code |
| polarity | output | 1 | Captured polarity |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the ground interval |

## Verification
The bench builds the block with TW=8, NW=4 and AW=14, small enough that every tick setting can be driven to 0, 1 and a few cycles, and pulse counts of 0, 1 and several can be run in full. A behavioural model expands each accepted start into the expected per-cycle precharge, strobe, busy and done pattern and compares it on every cycle, which covers back-to-back starts issued in the done cycle, aborts in the middle of a burst, and input changes made while an operation is running.

// File: rtl/hb_write_seq.sv
module hb_write_seq #(
  parameter int TW = 8,
  parameter int NW = 4,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [TW-1:0] settle_ticks,
  input  logic [TW-1:0] width_ticks,
  input  logic [TW-1:0] gap_ticks,
  input  logic [TW-1:0] gnd_ticks,
  input  logic [NW-1:0] pulse_count,
  input  logic [AW-1:0] amp_in,
  input  logic          pol_in,
  output logic          precharge_en,
  output logic          strobe,
  output logic [AW-1:0] amp_code,
  output logic          polarity,
  output logic          busy,
  output logic          done
);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_PULSE, S_GAP, S_GND} st_t;

  st_t           st;
  logic [TW-1:0] cnt, w_l, g_l, z_l;
  logic [NW-1:0] rem;
  logic [AW-1:0] amp_l;
  logic          pol_l;

  function automatic logic [TW-1:0] last(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign busy         = (st != S_IDLE);
  assign precharge_en = (st == S_SETTLE) || (st == S_PULSE) || (st == S_GAP);
  assign strobe       = (st == S_PULSE);
  assign amp_code     = busy ? amp_l : '0;
  assign polarity     = busy & pol_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      rem   <= '0;
      w_l   <= '0;
      g_l   <= '0;
      z_l   <= '0;
      amp_l <= '0;
      pol_l <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else if (st == S_IDLE) begin
        if (start) begin
          st    <= S_SETTLE;
          cnt   <= last(settle_ticks);
          w_l   <= width_ticks;
          g_l   <= gap_ticks;
          z_l   <= gnd_ticks;
          rem   <= (pulse_count == '0) ? NW'(1) : pulse_count;
          amp_l <= amp_in;
          pol_l <= pol_in;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        unique case (st)
          S_SETTLE, S_GAP: begin
            st  <= S_PULSE;
            cnt <= last(w_l);
          end
          S_PULSE: begin
            if (rem > NW'(1)) begin
              st  <= S_GAP;
              rem <= rem - 1'b1;
              cnt <= last(g_l);
            end else begin
              st  <= S_GND;
              cnt <= last(z_l);
            end
          end
          S_GND: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_strobe_has_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> precharge_en);

  p_pre_before_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(precharge_en));

  p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!strobe && !precharge_en && !busy && !done));

  p_done_after_ground_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !$past(precharge_en)));

  p_amp_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(amp_code) && $stable(polarity)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (amp_code == '0 && !polarity && !strobe && !precharge_en));

endmodule

// File: tb/sim_hb_write_seq.sv
`timescale 1ns/1ps
module sim_hb_write_seq;
  localparam int TW = 8, NW = 4, AW = 14;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0, pol_in = 1'b0;
  logic [TW-1:0] settle_ticks = '0, width_ticks = '0, gap_ticks = '0, gnd_ticks = '0;
  logic [NW-1:0] pulse_count = '0;
  logic [AW-1:0] amp_in = '0;
  logic precharge_en, strobe, polarity, busy, done;
  logic [AW-1:0] amp_code;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hb_write_seq #(.TW(TW), .NW(NW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .settle_ticks(settle_ticks), .width_ticks(width_ticks), .gap_ticks(gap_ticks),
    .gnd_ticks(gnd_ticks), .pulse_count(pulse_count), .amp_in(amp_in), .pol_in(pol_in),
    .precharge_en(precharge_en), .strobe(strobe), .amp_code(amp_code),
    .polarity(polarity), .busy(busy), .done(done));

  // model: each entry is {busy, precharge, strobe, done}
  logic [3:0] q[$];
  logic [3:0] e = 4'b0;
  logic [AW-1:0] m_amp = '0;
  logic m_pol = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      e = 4'b0;
    end else begin
      if (abort) q.delete();
      else if (q.size() == 0 && start) begin
        int s, w, g, z, n;
        s = (settle_ticks == 0) ? 1 : int'(settle_ticks);
        w = (width_ticks == 0) ? 1 : int'(width_ticks);
        g = (gap_ticks == 0) ? 1 : int'(gap_ticks);
        z = (gnd_ticks == 0) ? 1 : int'(gnd_ticks);
        n = (pulse_count == 0) ? 1 : int'(pulse_count);
        m_amp = amp_in;
        m_pol = pol_in;
        for (int i = 0; i < s; i++) q.push_back(4'b1100);
        for (int p = 0; p < n; p++) begin
          for (int i = 0; i < w; i++) q.push_back(4'b1110);
          if (p != n - 1) for (int i = 0; i < g; i++) q.push_back(4'b1100);
        end
        for (int i = 0; i < z; i++) q.push_back(4'b1000);
        q.push_back(4'b0001);
      end
      e = (q.size() > 0) ? q.pop_front() : 4'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      chk("R1 precharge_en", 32'(precharge_en), 32'(e[2]));
      chk("R2 strobe", 32'(strobe), 32'(e[1]));
      chk("R8 busy", 32'(busy), 32'(e[3]));
      chk("R5 done", 32'(done), 32'(e[0]));
      chk("R7 amp_code", 32'(amp_code), e[3] ? 32'(m_amp) : 32'd0);
      chk("R7 polarity", 32'(polarity), e[3] ? 32'(m_pol) : 32'd0);
    end
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic go(input int s, input int w, input int g, input int z, input int n,
                    input int a, input bit p);
    @(negedge clk);
    settle_ticks = TW'(s); width_ticks = TW'(w); gap_ticks = TW'(g);
    gnd_ticks = TW'(z); pulse_count = NW'(n); amp_in = AW'(a); pol_in = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset outputs", {26'd0, precharge_en, strobe, busy, done, polarity, |amp_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R5: single pulse
    go(3, 2, 1, 4, 1, 14'h1A5, 1'b1);
    wait_idle();
    // R3: burst of three pulses with gaps
    go(2, 3, 2, 2, 3, 14'h3FFF, 1'b0);
    wait_idle();
    // R4: zero ticks and zero pulse count
    go(0, 0, 0, 0, 0, 14'h0007, 1'b1);
    wait_idle();
    // R4 R3: zero gap inside a burst
    go(1, 1, 0, 1, 4, 14'h0100, 1'b0);
    wait_idle();
    // R6: abort in the middle of a burst
    go(2, 3, 3, 2, 5, 14'h0ABC, 1'b1);
    repeat (9) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (6) @(negedge clk);
    // R7 R8: inputs and start changed while busy are ignored
    go(4, 2, 2, 3, 2, 14'h0055, 1'b0);
    repeat (3) @(negedge clk);
    amp_in = 14'h2222; pol_in = 1'b1; width_ticks = 8'd9; pulse_count = 4'd7;
    start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    wait_idle();
    // R5 R8: start held through done launches the next operation at once
    settle_ticks = 8'd1; width_ticks = 8'd1; gnd_ticks = 8'd1; pulse_count = 4'd1;
    amp_in = 14'h0333; start = 1'b1;
    repeat (12) @(negedge clk);
    start = 1'b0;
    wait_idle();
    // R6: abort at the same edge as start in idle keeps the block idle
    settle_ticks = 8'd2; start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule